// File: doc/BRIEF.md
# Configurable Header-Vector ALU Pipeline

This block is a feedforward datapath that transforms a packet header vector (a set of fixed-width containers) as it moves through a fixed number of stages. Each stage holds a fixed number of ALUs. For every ALU, two operand selectors pick header containers. The ALU then either computes a stateless arithmetic result or reads and updates a state register of its own. A write-back selector for each container decides which ALU result, if any, replaces that container before the vector is registered into the next stage.

All routing and all operations come from a configuration bank, which is written through an address/data port while no traffic is flowing. After reset, every container passes through unchanged and all state is zero. A new vector can enter on every clock, and a valid flag travels with each vector. State registers change only for valid vectors. An update made for one vector is seen by the next vector that reaches the same ALU.

Top module: `phv_alu_pipe`

## Requirements
- R1: A vector presented with `in_valid` high at a rising edge appears on `out_phv` with `out_valid` high exactly DEPTH rising edges later. A new vector is accepted on every edge. `out_valid` is low for the edges that carry no vector.
- R2: After reset, `out_valid` is low, every container write-back selector selects pass-through, every ALU word is zero and every state register is zero. An unconfigured pipeline outputs each vector unchanged.
- R3: ALU word bits [11:10] select the container index (0..3) for operand A, and bits [13:12] select the container index for operand B.
- R4: Bit 14 selects the arithmetic: 0 adds, 1 subtracts. All results wrap modulo 1024.
- R5: The second operand X comes from the immediate in bits [9:0] when bit 15 is 1, and from operand B when bit 15 is 0. When bit 16 is 0, X is forced to zero.
- R6: Each container has a write-back select word. Value k below WIDTH writes the result of ALU k of that stage. Value WIDTH or higher keeps the container's incoming value. Stage 1 operates on the values that stage 0 wrote.
- R7: When bit 17 is 1, the ALU is stateful. It compares A with B using bits [19:18] (0: A<B, 1: A>=B, 2: A==B, 3: A!=B, all unsigned). If the comparison holds, the new state is state op X. The ALU result is the new state.
- R8: When a stateful comparison fails, bit 20 selects the else branch: 0 keeps the state, 1 loads operand A into the state.
- R9: The state update made for one vector is used by the very next vector through that ALU, including back-to-back vectors. A cycle with `in_valid` low leaves the state unchanged whatever the input data is.
- R10: Configuration addresses 0..DEPTH*WIDTH-1 hold ALU words at stage*WIDTH+alu. The following DEPTH*NCONT addresses hold write-back selects at DEPTH*WIDTH+stage*NCONT+container. `cfg_we` is only raised while `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | AW | Configuration word address |
| cfg_wdata | input | CFGW | Configuration word data |
| in_valid | input | 1 | Input vector valid |
| in_phv | input | NCONT*CW | Input vector, container k at bits k*CW+:CW |
| out_valid | output | 1 | Output vector valid |
| out_phv | output | NCONT*CW | Output vector after the last stage |

## Verification
The hardest case to create is a state register updating for one vector while the following vector is already reading it. A second hard case is a bubble whose stale data would satisfy the comparison if it were treated as valid. The stimulus sends stateful vectors back to back, then inserts an invalid cycle carrying data that meets the condition, then sends another valid vector. Each expected value is derived from the running state sequence. The stimulus also walks all four comparison codes and both else modes, and drives the state through zero so that wrap-around in both directions is observed.

// File: rtl/phv_alu_pipe.sv
module phv_alu_pipe #(
  parameter int DEPTH = 2,
  parameter int WIDTH = 2,
  parameter int NCONT = 4,
  parameter int CW    = 10,
  parameter int AW    = 8,
  localparam int SELW = (NCONT > 1) ? $clog2(NCONT) : 1,
  localparam int CFGW = CW + 2*SELW + 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [AW-1:0]       cfg_addr,
  input  logic [CFGW-1:0]     cfg_wdata,
  input  logic                in_valid,
  input  logic [NCONT*CW-1:0] in_phv,
  output logic                out_valid,
  output logic [NCONT*CW-1:0] out_phv
);
  localparam int OSW    = $clog2(WIDTH + 1);
  localparam int PW     = NCONT * CW;
  localparam int NALU   = DEPTH * WIDTH;
  localparam int NOS    = DEPTH * NCONT;
  localparam int F_SA   = CW;
  localparam int F_SB   = CW + SELW;
  localparam int F_SUB  = CW + 2*SELW;
  localparam int F_BSRC = F_SUB + 1;
  localparam int F_OPT  = F_SUB + 2;
  localparam int F_STF  = F_SUB + 3;
  localparam int F_REL  = F_SUB + 4;
  localparam int F_UPD  = F_SUB + 6;

  logic [CFGW-1:0] acfg [NALU];
  logic [OSW-1:0]  osel [NOS];
  logic [PW-1:0]   pq   [DEPTH];
  logic            vq   [DEPTH];
  logic [CW-1:0]   st   [NALU];
  logic [PW-1:0]   sin  [DEPTH];
  logic [PW-1:0]   sout [DEPTH];
  logic            sv   [DEPTH];
  logic [CW-1:0]   res  [NALU];
  logic [CW-1:0]   snx  [NALU];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NALU; i++) acfg[i] <= '0;
      for (int i = 0; i < NOS; i++)  osel[i] <= OSW'(WIDTH);
    end else if (cfg_we) begin
      for (int i = 0; i < NALU; i++)
        if (int'(cfg_addr) == i) acfg[i] <= cfg_wdata;
      for (int i = 0; i < NOS; i++)
        if (int'(cfg_addr) == i + NALU) osel[i] <= cfg_wdata[OSW-1:0];
    end
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign sin[s] = in_phv;
      assign sv[s]  = in_valid;
    end else begin : g_next
      assign sin[s] = pq[s-1];
      assign sv[s]  = vq[s-1];
    end

    for (genvar a = 0; a < WIDTH; a++) begin : g_alu
      localparam int K = s*WIDTH + a;
      logic [CW-1:0]   opa, opb, x, base, ar, nx;
      logic [SELW-1:0] sa, sb;
      logic            hit;
      assign sa = acfg[K][F_SA +: SELW];
      assign sb = acfg[K][F_SB +: SELW];
      assign opa = sin[s][sa*CW +: CW];
      assign opb = sin[s][sb*CW +: CW];
      assign x = !acfg[K][F_OPT] ? '0 : (acfg[K][F_BSRC] ? acfg[K][CW-1:0] : opb);
      assign base = acfg[K][F_STF] ? st[K] : opa;
      assign ar = acfg[K][F_SUB] ? base - x : base + x;
      always_comb begin
        case (acfg[K][F_REL +: 2])
          2'd0:    hit = opa <  opb;
          2'd1:    hit = opa >= opb;
          2'd2:    hit = opa == opb;
          default: hit = opa != opb;
        endcase
      end
      assign nx = hit ? ar : (acfg[K][F_UPD] ? opa : st[K]);
      assign snx[K] = nx;
      assign res[K] = acfg[K][F_STF] ? nx : ar;
    end

    for (genvar c = 0; c < NCONT; c++) begin : g_wb
      localparam int J = s*NCONT + c;
      logic [CW-1:0] o;
      always_comb begin
        o = sin[s][c*CW +: CW];
        for (int a = 0; a < WIDTH; a++)
          if (osel[J] == OSW'(a)) o = res[s*WIDTH + a];
      end
      assign sout[s][c*CW +: CW] = o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < DEPTH; s++) begin
        vq[s] <= 1'b0;
        pq[s] <= '0;
      end
      for (int k = 0; k < NALU; k++) st[k] <= '0;
    end else begin
      for (int s = 0; s < DEPTH; s++) begin
        vq[s] <= sv[s];
        pq[s] <= sout[s];
      end
      for (int k = 0; k < NALU; k++)
        if (sv[k / WIDTH] && acfg[k][F_STF]) st[k] <= snx[k];
    end
  end

  assign out_phv   = pq[DEPTH-1];
  assign out_valid = vq[DEPTH-1];
endmodule

// File: rtl/phv_alu_pipe_chk.sv
module phv_alu_pipe_chk #(
  parameter int DEPTH = 2,
  parameter int WIDTH = 2,
  parameter int NCONT = 4,
  parameter int CW    = 10
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_we,
  input logic                in_valid,
  input logic                out_valid,
  input logic [NCONT*CW-1:0] out_phv,
  input logic                sv [DEPTH],
  input logic [CW-1:0]       st [DEPTH*WIDTH]
);
  logic vsh [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) vsh[i] <= 1'b0;
    end else begin
      vsh[0] <= in_valid;
      for (int i = 1; i < DEPTH; i++) vsh[i] <= vsh[i-1];
    end
  end

  p_valid_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vsh[DEPTH-1]);

  p_out_known_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !$isunknown(out_phv));

  p_cfg_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> !in_valid);

  for (genvar k = 0; k < DEPTH*WIDTH; k++) begin : g_st
    p_state_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !sv[k / WIDTH] |=> $stable(st[k]));
  end
endmodule

bind phv_alu_pipe phv_alu_pipe_chk #(
  .DEPTH(DEPTH), .WIDTH(WIDTH), .NCONT(NCONT), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .in_valid(in_valid),
  .out_valid(out_valid), .out_phv(out_phv), .sv(sv), .st(st)
);

// File: tb/test_phv_alu_pipe.sv
module test_phv_alu_pipe;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [20:0] cfg_wdata = '0;
  logic        in_valid = 1'b0;
  logic [39:0] in_phv = '0;
  logic        out_valid;
  logic [39:0] out_phv;

  int tests = 0;
  int errors = 0;

  logic [39:0] q_in [8];
  logic [39:0] q_exp [8];
  logic        q_v [8];

  localparam logic [39:0] TV_IN [5] = '{
    {10'd20,   10'd10,  10'd2,   10'd1},
    {10'd0,    10'd3,   10'd30,  10'd1000},
    {10'd0,    10'd0,   10'd0,   10'd0},
    {10'd1,    10'd100, 10'd512, 10'd512},
    {10'd1023, 10'd5,   10'd200, 10'd100}
  };
  localparam logic [39:0] TV_EXP [5] = '{
    {10'd17,   10'd5,    10'd2,   10'd3},
    {10'd1018, 10'd1022, 10'd30,  10'd6},
    {10'd0,    10'd1019, 10'd0,   10'd0},
    {10'd1,    10'd95,   10'd512, 10'd0},
    {10'd723,  10'd0,    10'd200, 10'd300}
  };

  always #10 clk = ~clk;

  phv_alu_pipe i_phv_alu_pipe (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_phv(in_phv),
    .out_valid(out_valid), .out_phv(out_phv)
  );

  function automatic logic [39:0] mk(int c0, int c1, int c2, int c3);
    return {10'(c3), 10'(c2), 10'(c1), 10'(c0)};
  endfunction

  function automatic logic [20:0] aw(int imm, int sa, int sb, int sub, int bsrc,
                                     int opt, int stf, int rel, int upd);
    return {1'(upd), 2'(rel), 1'(stf), 1'(opt), 1'(bsrc), 1'(sub),
            2'(sb), 2'(sa), 10'(imm)};
  endfunction

  task automatic chk(string req, logic [39:0] act, logic [39:0] exp);
    tests++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk1(string req, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s valid: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic wcfg(int addr, logic [20:0] data);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_addr = 8'(addr);
    cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic put(int i, logic v, logic [39:0] din, logic [39:0] dexp);
    q_v[i] = v;
    q_in[i] = din;
    q_exp[i] = dexp;
  endtask

  task automatic run_seq(int n, string req);
    for (int i = 0; i < n + LAT; i++) begin
      @(negedge clk);
      if (i >= LAT) begin
        if (q_v[i-LAT]) begin
          chk1(req, out_valid, 1'b1);
          chk(req, out_phv, q_exp[i-LAT]);
        end else begin
          chk1(req, out_valid, 1'b0);
        end
      end else if (i == 1) begin
        chk1("R1", out_valid, 1'b0);
      end
      if (i < n) begin
        in_valid = q_v[i];
        in_phv = q_in[i];
      end else begin
        in_valid = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk1("R2", out_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk1("R2", out_valid, 1'b0);

    // R2 pass-through when unconfigured, R1 back-to-back timing
    put(0, 1'b1, mk(11, 22, 33, 44), mk(11, 22, 33, 44));
    put(1, 1'b1, mk(1023, 0, 7, 512), mk(1023, 0, 7, 512));
    put(2, 1'b0, mk(5, 5, 5, 5), '0);
    run_seq(3, "R2");

    // R3 R4 R5 R6 stateless configuration, two stages chained
    wcfg(0, aw(0, 0, 1, 0, 0, 1, 0, 0, 0));
    wcfg(1, aw(5, 2, 0, 1, 1, 1, 0, 0, 0));
    wcfg(2, aw(0, 3, 0, 1, 0, 1, 0, 0, 0));
    wcfg(3, aw(7, 1, 0, 1, 1, 0, 0, 0, 0));
    wcfg(4, 21'd0);  wcfg(5, 21'd2);  wcfg(6, 21'd1);  wcfg(7, 21'd2);
    wcfg(8, 21'd2);  wcfg(9, 21'd1);  wcfg(10, 21'd2); wcfg(11, 21'd0);
    for (int i = 0; i < 5; i++) put(i, 1'b1, TV_IN[i], TV_EXP[i]);
    run_seq(5, "R3_R4_R5_R6");

    // R7 R9 stateful: A<B then state+3, else keep (R8 mode 0)
    wcfg(0, aw(3, 0, 1, 0, 1, 1, 1, 0, 0));
    wcfg(6, 21'd2); wcfg(9, 21'd2); wcfg(11, 21'd2);
    put(0, 1'b1, mk(1, 5, 0, 0), mk(3, 5, 0, 0));
    put(1, 1'b1, mk(1, 5, 0, 0), mk(6, 5, 0, 0));
    put(2, 1'b1, mk(9, 5, 0, 0), mk(6, 5, 0, 0));
    put(3, 1'b0, mk(0, 9, 0, 0), '0);
    put(4, 1'b1, mk(0, 1, 0, 0), mk(9, 1, 0, 0));
    run_seq(5, "R7_R8_R9");

    // R8 load on else, R7 A>=B subtract with wrap
    wcfg(0, aw(3, 0, 1, 1, 1, 1, 1, 1, 1));
    put(0, 1'b1, mk(2, 5, 0, 0), mk(2, 5, 0, 0));
    put(1, 1'b1, mk(7, 5, 0, 0), mk(1023, 5, 0, 0));
    put(2, 1'b1, mk(5, 5, 0, 0), mk(1020, 5, 0, 0));
    run_seq(3, "R8_R7");

    // R7 equal compare
    wcfg(0, aw(3, 0, 1, 0, 1, 1, 1, 2, 0));
    put(0, 1'b1, mk(4, 4, 0, 0), mk(1023, 4, 0, 0));
    put(1, 1'b1, mk(4, 5, 0, 0), mk(1023, 5, 0, 0));
    run_seq(2, "R7_eq");

    // R7 not-equal compare, wrap upward
    wcfg(0, aw(3, 0, 1, 0, 1, 1, 1, 3, 0));
    put(0, 1'b1, mk(4, 5, 0, 0), mk(2, 5, 0, 0));
    run_seq(1, "R7_ne");

    // R2 R9 reset clears state and config
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk1("R2", out_valid, 1'b0);
    rst_n = 1'b1;
    put(0, 1'b1, mk(8, 9, 10, 11), mk(8, 9, 10, 11));
    run_seq(1, "R2_cfg_reset");
    wcfg(0, aw(3, 0, 1, 0, 1, 1, 1, 3, 0));
    wcfg(4, 21'd0);
    put(0, 1'b1, mk(1, 2, 0, 0), mk(3, 2, 0, 0));
    run_seq(1, "R9_state_reset");

    $display("[TB] %0d tests run, %0d failed", tests, errors);
    $finish;
  end
endmodule